// File: doc/BRIEF.md
# Packetized Block-Write Data Sender with CRC-16

This block produces the data phase of a block write once the command has been accepted elsewhere. A single `start` pulse supplies a total byte count, a packet-size code and a CRC switch. The block then pulls payload bytes from an upstream valid/ready stream and emits a byte stream for the serial shifter.

The payload is cut into packets of a fixed power-of-two size. Each packet is preceded by a one-byte tag that marks it as first, inner or last. When CRC-16 is switched on, each packet is followed by its checksum. Packets are sent back to back: the block never waits for a reply between them. It raises a one-cycle `done` pulse after the final byte has gone out. Requests that are too short, or that carry an unsupported size code, are refused with a one-cycle `reject` pulse.

Payload bytes pass straight through from input to output. The output handshake therefore directly paces the upstream stream during the payload part of a packet.

Top module: `crc_packet_sender`

## Requirements
- R1: After reset the block is idle: `busy`, `out_valid`, `in_ready`, `done` and `reject` are all 0.
- R2: The packet size is 2^(8+code) bytes, where `size_code` is a 3-bit value from 0 to 5 (256 to 8192 bytes). Each packet except the last carries exactly that many payload bytes.
- R3: Each packet is preceded by a tag byte equal to 0xF0 OR an order value. The order value is 1 for the first packet, 2 for an inner packet and 3 for the last packet.
- R4: When the remaining count is at most one packet size, the packet carries all remaining bytes with order 3. A transfer that fits in one packet emits only the tag 0xF3.
- R5: With `crc_en` set, two checksum bytes follow each packet's payload, high byte first. The checksum uses polynomial 0x1021, processes bits MSB first, is preset to 0xFFFF, has no final XOR, covers only that packet's payload, and restarts for every packet.
- R6: With `crc_en` clear, no checksum bytes are emitted and each tag directly follows the previous payload.
- R7: No gap between packets: while `busy` and the upstream offers a byte, `out_valid` is 1, so the next tag is offered in the cycle right after a packet ends.
- R8: A `start` with `total_len` ≤ 4 or `size_code` > 5 yields a one-cycle `reject` in the next cycle. No bytes are emitted and the block stays idle.
- R9: `done` is a single-cycle pulse in the cycle after the final byte (payload or checksum) is accepted, and `busy` is 0 in that cycle.
- R10: An offered output byte stays valid and unchanged until accepted. `in_ready` is 1 only while `busy` and `out_ready` are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a transfer (sampled while idle) |
| total_len | input | LEN_W | Total payload byte count |
| size_code | input | 3 | Packet size code, size = 2^(8+code) |
| crc_en | input | 1 | Append CRC-16 after each packet |
| in_data | input | 8 | Upstream payload byte |
| in_valid | input | 1 | Upstream byte valid |
| in_ready | output | 1 | Upstream byte accepted |
| out_data | output | 8 | Byte to the serial shifter |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Shifter accepts the byte |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Final byte sent (one-cycle pulse) |
| reject | output | 1 | Request refused (one-cycle pulse) |

## Verification
A bad remaining-count or packet-count register shows up at the very next packet boundary. There, a tag byte appears one byte early or late, or carries the wrong order value. A wrong checksum register is visible in the two bytes that close the same packet, so the error surfaces at most one packet size after it arises. The bench compares every emitted byte with a stream rebuilt from the requirements, under both a free-running and a throttled output handshake. It also times `done` against the final acceptance to the exact cycle, so an off-by-one in the end condition is caught at once.

// File: rtl/crc_packet_sender.sv
module crc_packet_sender #(
  parameter int LEN_W    = 24,
  parameter int MIN_LOG  = 8,
  parameter int MAX_CODE = 5,
  parameter int MIN_LEN  = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LEN_W-1:0] total_len,
  input  logic [2:0]       size_code,
  input  logic             crc_en,
  input  logic [7:0]       in_data,
  input  logic             in_valid,
  output logic             in_ready,
  output logic [7:0]       out_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic             busy,
  output logic             done,
  output logic             reject
);
  localparam int PKT_W = MIN_LOG + MAX_CODE + 1;

  typedef enum logic [2:0] {S_IDLE, S_TAG, S_PAY, S_CRCH, S_CRCL} state_t;

  state_t           state;
  logic [LEN_W-1:0] rem;
  logic [PKT_W-1:0] pkt_left;
  logic [2:0]       code_q;
  logic             crc_on, first_q, last_q;
  logic [15:0]      crc;

  function automatic logic [15:0] crc_step(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] v;
    v = c ^ {b, 8'h00};
    for (int i = 0; i < 8; i++)
      v = v[15] ? ((v << 1) ^ 16'h1021) : (v << 1);
    return v;
  endfunction

  logic [PKT_W-1:0] psize;
  logic             fits;
  logic [1:0]       order;
  logic             fire;
  logic             bad_req;

  assign psize   = PKT_W'(1) << (MIN_LOG + int'(code_q));
  assign fits    = rem <= LEN_W'(psize);
  assign order   = fits ? 2'd3 : (first_q ? 2'd1 : 2'd2);
  assign bad_req = (total_len < LEN_W'(MIN_LEN)) || (size_code > 3'(MAX_CODE));

  always_comb begin
    out_valid = 1'b0;
    out_data  = 8'h00;
    case (state)
      S_TAG:  begin out_valid = 1'b1;     out_data = {6'b111100, order}; end
      S_PAY:  begin out_valid = in_valid; out_data = in_data;            end
      S_CRCH: begin out_valid = 1'b1;     out_data = crc[15:8];          end
      S_CRCL: begin out_valid = 1'b1;     out_data = crc[7:0];           end
      default: ;
    endcase
  end

  assign fire     = out_valid && out_ready;
  assign in_ready = (state == S_PAY) && out_ready;
  assign busy     = state != S_IDLE;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      rem      <= '0;
      pkt_left <= '0;
      code_q   <= '0;
      crc_on   <= 1'b0;
      first_q  <= 1'b0;
      last_q   <= 1'b0;
      crc      <= 16'hFFFF;
      done     <= 1'b0;
      reject   <= 1'b0;
    end else begin
      done   <= 1'b0;
      reject <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          if (bad_req) reject <= 1'b1;
          else begin
            rem     <= total_len;
            code_q  <= size_code;
            crc_on  <= crc_en;
            first_q <= 1'b1;
            state   <= S_TAG;
          end
        end
        S_TAG: if (fire) begin
          last_q   <= fits;
          pkt_left <= fits ? rem[PKT_W-1:0] : psize;
          first_q  <= 1'b0;
          crc      <= 16'hFFFF;
          state    <= S_PAY;
        end
        S_PAY: if (fire) begin
          crc      <= crc_step(crc, in_data);
          rem      <= rem - LEN_W'(1);
          pkt_left <= pkt_left - PKT_W'(1);
          if (pkt_left == PKT_W'(1)) begin
            if (crc_on)      state <= S_CRCH;
            else if (last_q) begin state <= S_IDLE; done <= 1'b1; end
            else             state <= S_TAG;
          end
        end
        S_CRCH: if (fire) state <= S_CRCL;
        S_CRCL: if (fire) begin
          if (last_q) begin state <= S_IDLE; done <= 1'b1; end
          else state <= S_TAG;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/crc_packet_sender_chk.sv
module crc_packet_sender_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       in_ready,
  input logic [7:0] out_data,
  input logic       out_valid,
  input logic       out_ready,
  input logic       busy,
  input logic       done,
  input logic       reject
);
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!out_valid && !in_ready));

  p_no_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && in_valid) |-> out_valid);

  p_reject_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    reject |-> (!busy && !out_valid));

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && in_valid) |=> (out_valid && $stable(out_data)));

  p_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (busy && out_ready));
endmodule

bind crc_packet_sender crc_packet_sender_chk u_chk (.*);

// File: tb/crc_packet_sender_bench.sv
module crc_packet_sender_bench;
  localparam int LEN_W = 24;
  localparam int NV    = 9;
  localparam int V_LEN   [NV] = '{5, 256, 257, 600, 1000, 2100, 4097, 8193, 9000};
  localparam int V_CODE  [NV] = '{0, 0, 0, 0, 1, 2, 3, 5, 4};
  localparam int V_CRC   [NV] = '{1, 1, 0, 1, 1, 0, 1, 1, 0};
  localparam int V_STALL [NV] = '{0, 1, 0, 1, 0, 1, 0, 1, 0};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [LEN_W-1:0] total_len = '0;
  logic [2:0] size_code = '0;
  logic crc_en = 1'b0;
  logic [7:0] in_data = '0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [7:0] out_data;
  logic out_valid;
  logic out_ready = 1'b0;
  logic busy, done, reject;

  int checks = 0;
  int fails = 0;
  int cyc = 0;

  logic [7:0] exp_b [16384];
  int exp_n;

  always #5 clk = ~clk;

  crc_packet_sender #(.LEN_W(LEN_W)) u_crc_packet_sender (
    .clk(clk), .rst_n(rst_n), .start(start), .total_len(total_len),
    .size_code(size_code), .crc_en(crc_en), .in_data(in_data),
    .in_valid(in_valid), .in_ready(in_ready), .out_data(out_data),
    .out_valid(out_valid), .out_ready(out_ready), .busy(busy),
    .done(done), .reject(reject));

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 180000) begin
        checks++;
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 180000);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
      end
    end
  end

  function automatic logic [7:0] src_byte(input int i, input int seed);
    return 8'(i * 13 + seed);
  endfunction

  function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] v = c;
    for (int k = 7; k >= 0; k--) begin
      if (v[15] ^ b[k]) v = (v << 1) ^ 16'h1021;
      else v = v << 1;
    end
    return v;
  endfunction

  task automatic build(input int len, input int code, input int crc, input int seed);
    int psz = 256 << code;
    int remn = len;
    int idx = 0;
    bit first = 1;
    exp_n = 0;
    while (remn > 0) begin
      int n = (remn <= psz) ? remn : psz;
      logic [15:0] c = 16'hFFFF;
      exp_b[exp_n++] = (remn <= psz) ? 8'hF3 : (first ? 8'hF1 : 8'hF2);
      for (int j = 0; j < n; j++) begin
        logic [7:0] b = src_byte(idx, seed);
        exp_b[exp_n++] = b;
        c = ref_crc(c, b);
        idx++;
      end
      if (crc != 0) begin
        exp_b[exp_n++] = c[15:8];
        exp_b[exp_n++] = c[7:0];
      end
      remn -= n;
      first = 0;
    end
  endtask

  task automatic run_vec(input int len, input int code, input int crc, input int stall, input int seed);
    int k = 0;
    int src_idx = 0;
    int it = 0;
    int last_hs = -10;
    int done_it = -1;
    int mism = 0;
    int gaps = 0;
    int rdy_bad = 0;
    int first_bad_act = 0;
    int first_bad_exp = 0;
    build(len, code, crc, seed);
    @(negedge clk);
    start = 1'b1;
    total_len = LEN_W'(len);
    size_code = 3'(code);
    crc_en = (crc != 0);
    while (done_it < 0 && it < 40000) begin
      @(negedge clk);
      start = 1'b0;
      out_ready = !(stall != 0 && (it % 3) == 2);
      in_valid = 1'b1;
      in_data = src_byte(src_idx, seed);
      #1;
      if (done) done_it = it;
      if (busy && !out_valid) gaps++;
      if (in_ready && !out_ready) rdy_bad++;
      if (in_valid && in_ready) src_idx++;
      if (out_valid && out_ready) begin
        if (k < exp_n && out_data != exp_b[k] && mism == 0) begin
          first_bad_act = out_data;
          first_bad_exp = exp_b[k];
          mism++;
        end
        k++;
        last_hs = it;
      end
      it++;
    end
    in_valid = 1'b0;
    check(mism == 0, "R2 R3 R4 R5 R6 R10 stream byte", first_bad_act, first_bad_exp);
    check(k == exp_n, "R2 byte count", k, exp_n);
    check(done_it == last_hs + 1, "R9 done timing", done_it, last_hs + 1);
    check(gaps == 0, "R7 gap while busy", gaps, 0);
    check(rdy_bad == 0, "R10 in_ready without out_ready", rdy_bad, 0);
    @(negedge clk);
    #1;
    check(!done && !busy, "R9 done single cycle", {done, busy}, 0);
  endtask

  task automatic try_reject(input int len, input int code);
    @(negedge clk);
    start = 1'b1;
    total_len = LEN_W'(len);
    size_code = 3'(code);
    @(negedge clk);
    start = 1'b0;
    #1;
    check(reject && !busy && !out_valid, "R8 reject pulse", {reject, busy, out_valid}, 3'b100);
    @(negedge clk);
    #1;
    check(!reject && !busy, "R8 reject one cycle and stays idle", {reject, busy}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check(!busy && !out_valid && !in_ready && !done && !reject, "R1 reset state",
          {busy, out_valid, in_ready, done, reject}, 0);
    rst_n = 1'b1;

    for (int v = 0; v < NV; v++)
      run_vec(V_LEN[v], V_CODE[v], V_CRC[v], V_STALL[v], v * 31 + 7);

    begin
      bit tag_ok;
      build(5, 0, 1, 3);
      tag_ok = (exp_n == 8) && (exp_b[0] == 8'hF3);
      check(tag_ok, "R4 single packet uses only tag F3 (model)", exp_n, 8);
    end

    try_reject(4, 0);
    try_reject(0, 2);
    try_reject(100, 6);

    @(negedge clk);
    start = 1'b1;
    total_len = LEN_W'(700);
    size_code = 3'd0;
    crc_en = 1'b1;
    @(negedge clk);
    start = 1'b0;
    out_ready = 1'b1;
    in_valid = 1'b1;
    repeat (20) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    #1;
    check(!busy && !out_valid && !in_ready && !done, "R1 reset mid-transfer",
          {busy, out_valid, in_ready, done}, 0);
    rst_n = 1'b1;
    in_valid = 1'b0;

    run_vec(300, 0, 1, 1, 99);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule